// File: doc/BRIEF.md
# Alarm Real-Time Clock with Trimmable Prescaler

This block keeps a 32-bit seconds count for a chip that has a slow reference clock. A strobe that marks each cycle of the 32.768 kHz reference enters through `ref_tick`, which is synchronous to the bus clock. A prescaler counts these strobes. Each time it has seen a programmable number of them, it issues one tick, and the tick advances the seconds counter. With the divisor at its reset value, the counter advances once per second.

Software programs the block through a small synchronous register bus. The bus has four registers: a compare value, the live count, the prescaler divisor, and a status word. The status word holds two sticky event flags next to their two enables. One event fires on every tick. The other fires on the tick at which the counter reaches the compare value. Each flag drives a level interrupt line. Software clears a flag by writing 1 to that flag's bit.

Top module: `alarm_rtc`

## Requirements
- R1: After synchronous reset, the compare, count and status registers read 0, the divisor register reads 32767, and both interrupt outputs are low.
- R2: Byte offsets decode as follows: 0x00 is the compare register, 0x04 the count, 0x08 the divisor (low 16 bits are stored, upper bits read 0), and 0x10 the status. Any other offset reads 0, and a write to it changes nothing.
- R3: The count increases by exactly 1 once every (divisor + 1) `ref_tick` strobes. Without strobes it holds its value.
- R4: A write to the divisor register restarts the prescaler from zero. A strobe in the same cycle does not produce a tick, and the next tick follows (new divisor + 1) strobes later.
- R5: A write to the count register loads the written value and restarts the prescaler from zero. A tick that would have fallen in the same cycle is dropped.
- R6: The one-second flag (status bit 1) is set on a tick only while its enable (status bit 3) is 1.
- R7: The alarm flag (status bit 0) is set on the tick at which the count becomes equal to the compare register, only while the alarm enable (status bit 2) is 1.
- R8: A write to the status register loads bits 3:2 into the two enables, and a 1 in bit 0 or bit 1 clears the matching flag. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq_alarm` equals the alarm flag and `irq_sec` equals the one-second flag. A flag stays set until a write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq_alarm | output | 1 | Alarm interrupt level |
| irq_sec | output | 1 | Once-per-tick interrupt level |

## Verification
The bench targets four collisions:
- A strobe in the same cycle as a divisor or count write. A design that lets this tick through counts one too many.
- A status write that clears a flag in the same cycle a tick sets it. A design that lets the clear win loses an event.
- The alarm compare. A design that compares the pre-increment count raises the alarm one tick late.
- Reads of unmapped offsets and writes to them. A design with loose decode aliases them onto real registers.

Divisors 0 and 1 exercise the shortest tick spacing. A long random run with small divisors and mixed writes is compared against a cycle model computed in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam logic [15:0] OFS_ALARM  = 16'h0000;
    localparam logic [15:0] OFS_COUNT  = 16'h0004;
    localparam logic [15:0] OFS_TRIM   = 16'h0008;
    localparam logic [15:0] OFS_STATUS = 16'h0010;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ALARM,
        SEL_COUNT,
        SEL_TRIM,
        SEL_STATUS
    } reg_sel_e;

    // Packed order places sec_en at bit 3 and alarm_flag at bit 0.
    typedef struct packed {
        logic sec_en;
        logic alarm_en;
        logic sec_flag;
        logic alarm_flag;
    } rtc_status_t;

    localparam int unsigned STATUS_W = $bits(rtc_status_t);

    function automatic reg_sel_e decode_offset(input logic [15:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_ALARM:  sel = SEL_ALARM;
            OFS_COUNT:  sel = SEL_COUNT;
            OFS_TRIM:   sel = SEL_TRIM;
            OFS_STATUS: sel = SEL_STATUS;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic             wrap;

    assign wrap = (phase_q == divisor);
    assign tick = ref_tick && wrap && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (ref_tick) begin
            phase_q <= wrap ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                alarm_hit,
    input  logic                wr,
    input  logic [STATUS_W-1:0] wdata,
    output rtc_status_t         status
);
    rtc_status_t st_q;
    rtc_status_t wr_view;
    logic        set_sec;
    logic        set_alarm;
    logic        clr_sec;
    logic        clr_alarm;

    assign wr_view   = rtc_status_t'(wdata);
    assign set_sec   = tick && st_q.sec_en;
    assign set_alarm = tick && alarm_hit && st_q.alarm_en;
    assign clr_sec   = wr && wr_view.sec_flag;
    assign clr_alarm = wr && wr_view.alarm_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.sec_flag   <= (st_q.sec_flag && !clr_sec) || set_sec;
            st_q.alarm_flag <= (st_q.alarm_flag && !clr_alarm) || set_alarm;
            if (wr) begin
                st_q.sec_en   <= wr_view.sec_en;
                st_q.alarm_en <= wr_view.alarm_en;
            end
        end
    end

    assign status = st_q;
endmodule

// File: rtl/alarm_rtc.sv
module alarm_rtc
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned DIV_RESET = 32767
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_alarm,
    output logic              irq_sec
);
    localparam int unsigned OFS_W = 16;

    reg_sel_e         sel;
    logic [OFS_W-1:0] ofs_ext;
    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] count_q;
    logic [DIV_W-1:0] div_q;
    logic             wr_alarm;
    logic             wr_count;
    logic             wr_div;
    logic             wr_status;
    logic             sec_tick;
    logic             alarm_hit;
    rtc_status_t      status;

    assign ofs_ext   = OFS_W'(addr);
    assign sel       = decode_offset(ofs_ext);
    assign wr_alarm  = wr_en && (sel == SEL_ALARM);
    assign wr_count  = wr_en && (sel == SEL_COUNT);
    assign wr_div    = wr_en && (sel == SEL_TRIM);
    assign wr_status = wr_en && (sel == SEL_STATUS);

    rtc_prescaler #(.DIV_W(DIV_W)) u_prescaler (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .restart  (wr_count || wr_div),
        .divisor  (div_q),
        .tick     (sec_tick)
    );

    // The compare looks at the value the count takes on this tick.
    assign alarm_hit = ((count_q + 1'b1) == alarm_q);

    rtc_status u_status (
        .clk       (clk),
        .rst       (rst),
        .tick      (sec_tick),
        .alarm_hit (alarm_hit),
        .wr        (wr_status),
        .wdata     (wr_data[STATUS_W-1:0]),
        .status    (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
            count_q <= '0;
            div_q   <= DIV_W'(DIV_RESET);
        end else begin
            if (wr_alarm) alarm_q <= wr_data[CNT_W-1:0];
            if (wr_div)   div_q   <= wr_data[DIV_W-1:0];
            if (wr_count)      count_q <= wr_data[CNT_W-1:0];
            else if (sec_tick) count_q <= count_q + 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_ALARM:  rd_data = DATA_W'(alarm_q);
            SEL_COUNT:  rd_data = DATA_W'(count_q);
            SEL_TRIM:   rd_data = DATA_W'(div_q);
            SEL_STATUS: rd_data = DATA_W'(status);
            default:    rd_data = '0;
        endcase
    end

    assign irq_alarm = status.alarm_flag;
    assign irq_sec   = status.sec_flag;
endmodule

// File: rtl/alarm_rtc_checker.sv
module alarm_rtc_checker #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_tick,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_alarm,
    input logic              irq_sec,
    input logic              sec_tick,
    input logic [CNT_W-1:0]  count_q
);
    logic cnt_wr;
    logic sts_wr;
    assign cnt_wr = wr_en && (addr == ADDR_W'(4));
    assign sts_wr = wr_en && (addr == ADDR_W'(16));

    // R3
    tick_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> ref_tick);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));

    // R5
    count_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> count_q == $past(wr_data[CNT_W-1:0]));

    // R6
    sec_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_sec && !sec_tick) |=> !irq_sec);

    // R7
    alarm_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_alarm && !sec_tick) |=> !irq_alarm);

    // R9
    sec_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_sec && !(sts_wr && wr_data[1])) |=> irq_sec);

    // R9
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_alarm && !(sts_wr && wr_data[0])) |=> irq_alarm);
endmodule

bind alarm_rtc alarm_rtc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq_alarm (irq_alarm),
    .irq_sec   (irq_sec),
    .sec_tick  (sec_tick),
    .count_q   (count_q)
);

// File: tb/alarm_rtc_tb.sv
module alarm_rtc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_alarm;
    logic        irq_sec;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Bench model state, derived from the requirements
    logic [31:0] m_alarm, m_cnt;
    logic [15:0] m_div, m_phase;
    logic        m_sec_en, m_al_en, m_sec_f, m_al_f;

    always #5 clk = ~clk;

    alarm_rtc u_dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_alarm(irq_alarm), .irq_sec(irq_sec)
    );

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00:   return m_alarm;
            5'h04:   return m_cnt;
            5'h08:   return {16'h0, m_div};
            5'h10:   return {28'h0, m_sec_en, m_al_en, m_sec_f, m_al_f};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_alarm = '0; m_cnt = '0; m_div = 16'd32767; m_phase = '0;
        m_sec_en = 0; m_al_en = 0; m_sec_f = 0; m_al_f = 0;
    endtask

    task automatic model_step(input logic rt, input logic we,
                              input logic [4:0] a, input logic [31:0] d);
        logic restart, tk, s_sec, s_al;
        restart = we && (a == 5'h04 || a == 5'h08);
        tk      = rt && (m_phase == m_div) && !restart;
        s_sec   = tk && m_sec_en;
        s_al    = tk && m_al_en && ((m_cnt + 32'd1) == m_alarm);
        if (restart)  m_phase = '0;
        else if (rt)  m_phase = (m_phase == m_div) ? 16'd0 : m_phase + 16'd1;
        if (we && a == 5'h10) begin
            m_sec_f  = (m_sec_f && !d[1]) || s_sec;
            m_al_f   = (m_al_f && !d[0]) || s_al;
            m_sec_en = d[3];
            m_al_en  = d[2];
        end else begin
            m_sec_f = m_sec_f || s_sec;
            m_al_f  = m_al_f || s_al;
        end
        if (we && a == 5'h04) m_cnt = d;
        else if (tk)          m_cnt = m_cnt + 32'd1;
        if (we && a == 5'h00) m_alarm = d;
        if (we && a == 5'h08) m_div = d[15:0];
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One bus cycle; irqs compared after the edge.
    task automatic cyc(input string tag, input logic rt, input logic we,
                       input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        ref_tick = rt; wr_en = we; addr = a; wr_data = d;
        @(posedge clk);
        model_step(rt, we, a, d);
        #1;
        check(tag, "irq_alarm", {31'h0, irq_alarm}, {31'h0, m_al_f});
        check(tag, "irq_sec", {31'h0, irq_sec}, {31'h0, m_sec_f});
    endtask

    task automatic rd(input string tag, input logic [4:0] a);
        @(negedge clk);
        ref_tick = 0; wr_en = 0; addr = a;
        #1;
        check(tag, "rd_data", rd_data, exp_read(a));
        @(posedge clk);
        model_step(1'b0, 1'b0, a, 32'h0);
    endtask

    task automatic wr(input string tag, input logic [4:0] a, input logic [31:0] d);
        cyc(tag, 1'b0, 1'b1, a, d);
    endtask

    task automatic strobes(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1'b1, 1'b0, 5'h1f, 32'h0);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        rd("R1", 5'h00); rd("R1", 5'h04); rd("R1", 5'h08); rd("R1", 5'h10);
        check("R1", "irq_sec", {31'h0, irq_sec}, 32'h0);

        // R2 map, unmapped offsets
        wr("R2", 5'h00, 32'hdead_beef); rd("R2", 5'h00);
        wr("R2", 5'h08, 32'hffff_0003); rd("R2", 5'h08);
        wr("R2", 5'h0c, 32'hffff_ffff); rd("R2", 5'h0c);
        rd("R2", 5'h00); rd("R2", 5'h04); rd("R2", 5'h14);

        // R3 R6 count and one-second flag with divisor 3
        wr("R6", 5'h10, 32'h8);
        strobes("R3", 3); rd("R3", 5'h04);
        strobes("R6", 1); rd("R3", 5'h04); rd("R6", 5'h10);
        // R8 clear while keeping enable
        wr("R8", 5'h10, 32'hA); rd("R8", 5'h10);
        // R6 disabled: ticks leave flag clear
        wr("R6", 5'h10, 32'h0); strobes("R6", 8); rd("R6", 5'h10); rd("R3", 5'h04);

        // R7 alarm two ticks ahead
        wr("R7", 5'h00, m_cnt + 2); wr("R7", 5'h10, 32'h4);
        strobes("R7", 4); rd("R7", 5'h10);
        strobes("R7", 4); rd("R7", 5'h10);
        wr("R7", 5'h10, 32'h5); rd("R7", 5'h10);
        // R7 disabled alarm does not fire
        wr("R7", 5'h00, m_cnt + 1); wr("R7", 5'h10, 32'h0);
        strobes("R7", 4); rd("R7", 5'h10);

        // R5 count write mid-prescale and collision with strobe
        strobes("R5", 2);
        wr("R5", 5'h04, 32'hffff_fffe); strobes("R5", 3); rd("R5", 5'h04);
        strobes("R5", 1); rd("R5", 5'h04);
        strobes("R5", 3);
        cyc("R5", 1'b1, 1'b1, 5'h04, 32'h100); rd("R5", 5'h04);

        // R4 divisor write with strobe collision, then divisor 0
        strobes("R4", 2);
        cyc("R4", 1'b1, 1'b1, 5'h08, 32'h1); strobes("R4", 1); rd("R4", 5'h04);
        strobes("R4", 1); rd("R4", 5'h04);
        wr("R4", 5'h08, 32'h0); strobes("R4", 5); rd("R4", 5'h04);

        // R8 set and clear in the same cycle: set wins
        wr("R8", 5'h10, 32'h8);
        cyc("R8", 1'b1, 1'b1, 5'h10, 32'hA); rd("R8", 5'h10);

        // R9 random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic [4:0]  a;
            logic [31:0] d;
            int          p;
            p = $urandom_range(0, 99);
            case ($urandom_range(0, 5))
                0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08;
                3: a = 5'h10; 4: a = 5'h10; default: a = 5'($urandom_range(0, 31));
            endcase
            d = $urandom();
            if (a == 5'h08) d = {d[31:16], 13'h0, d[2:0]};
            if (a == 5'h00) d = m_cnt + 32'($urandom_range(1, 3));
            if (p < 8)       cyc("R9", $urandom_range(0, 1) == 1, 1'b1, a, d);
            else if (p < 20) rd("R9", a);
            else             cyc("R9", $urandom_range(0, 2) != 0, 1'b0, a, 32'h0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule